// File: doc/BRIEF.md
# Vector Compress and Expand Unit

This block rearranges the elements of one vector register under a one-bit-per-element mask. In compress mode the elements whose mask bit is set are packed, lowest element first, into the bottom slots of the destination, and the number of packed elements is reported. Expand is the inverse. Elements are taken in turn from the bottom of the source and dropped, in ascending order, into the destination positions that have their mask bit set.

The unit is sequential and visits one element per clock. A start pulse captures the mode, the mask, the source vector and the destination's current contents. Eight scan cycles later a one-cycle done pulse marks the result as valid. The result holds on the outputs until the next accepted start. Destination slots that the operation does not write keep the captured initial contents, so the caller supplies the old destination register through `dst_init`.

Top module: `vec_pack_unit`

## Requirements
- R1: In compress mode (`mode`=0), destination slot k holds the source element with the k-th lowest set mask bit, for every k below the mask's population count.
- R2: In compress mode, destination slots at or above the packed length hold the value of `dst_init` captured at start.
- R3: From the done pulse until the next accepted start, `packed_len` equals the number of set bits in the captured mask, in both modes.
- R4: In expand mode (`mode`=1), the destination position with the k-th lowest set mask bit holds source element k.
- R5: In expand mode, destination positions whose mask bit is clear hold the value of `dst_init` captured at start.
- R6: `start` is accepted on a rising edge while `busy` is low. `busy` is high from that edge until the 8th following edge. `done` is a single-cycle pulse registered on that 8th edge.
- R7: A `start` pulse while `busy` is high is ignored. The running operation's result is not changed by the mode, mask or data presented with it.
- R8: An all-zero mask gives `packed_len` 0 and a destination equal to `dst_init`, in both modes.
- R9: After reset, `busy`, `done`, `packed_len` and every destination element are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; inputs are sampled with it |
| mode | input | 1 | 0 = compress, 1 = expand |
| mask | input | N | Element mask; bit i set marks element i active |
| src_vec | input | N*W | Source vector; element i occupies bits i*W +: W |
| dst_init | input | N*W | Previous destination contents |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| packed_len | output | $clog2(N+1) | Population count of the captured mask |
| dst_vec | output | N*W | Destination vector, same layout as the source |

## Verification
The rising edge that samples `start` is counted as edge zero. Busy must be visible just after that edge, and done must first be seen just after the eighth edge that follows it. The bench drives inputs on falling edges and polls `done` one falling edge at a time. It checks that the count is exactly eight, then compares `dst_vec` and `packed_len` in that same half cycle. That window is the only one guaranteed by R6. Every one of the 256 masks is run in both modes. A second start is injected mid-operation to confirm that it leaves the result unchanged.

// File: rtl/vec_pack_unit.sv
module vec_pack_unit #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   mode,
  input  logic [N-1:0]           mask,
  input  logic [N*W-1:0]         src_vec,
  input  logic [N*W-1:0]         dst_init,
  output logic                   busy,
  output logic                   done,
  output logic [$clog2(N+1)-1:0] packed_len,
  output logic [N*W-1:0]         dst_vec
);
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(N+1);

  logic [W-1:0]  src_q [N];
  logic [W-1:0]  dst_q [N];
  logic [N-1:0]  mask_q;
  logic          mode_q;
  logic          busy_q;
  logic          done_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;

  wire take = busy_q && mask_q[idx_q];
  wire last = idx_q == IW'(N-1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= 1'b0;
      mask_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < N; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        busy_q <= 1'b1;
        mode_q <= mode;
        mask_q <= mask;
        idx_q  <= '0;
        cnt_q  <= '0;
        for (int i = 0; i < N; i++) begin
          src_q[i] <= src_vec[i*W +: W];
          dst_q[i] <= dst_init[i*W +: W];
        end
      end else if (busy_q) begin
        if (take) begin
          if (!mode_q) dst_q[cnt_q[IW-1:0]] <= src_q[idx_q];
          else         dst_q[idx_q] <= src_q[cnt_q[IW-1:0]];
          cnt_q <= cnt_q + CW'(1);
        end
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        idx_q <= idx_q + IW'(1);
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign packed_len = cnt_q;

  for (genvar g = 0; g < N; g++) begin : g_out
    assign dst_vec[g*W +: W] = dst_q[g];
  end

  a_r6_done_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  a_r6_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  a_r3_len_popcount: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> packed_len == CW'($countones(mask_q)));
  a_r7_inputs_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mask_q) && $stable(mode_q));
endmodule

// File: tb/vec_pack_unit_tb_top.sv
module vec_pack_unit_tb_top;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int CW = $clog2(N+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [N-1:0] mask = '0;
  logic [N*W-1:0] src_vec = '0;
  logic [N*W-1:0] dst_init = '0;
  logic busy, done;
  logic [CW-1:0] packed_len;
  logic [N*W-1:0] dst_vec;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  vec_pack_unit #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .mask(mask),
    .src_vec(src_vec), .dst_init(dst_init), .busy(busy), .done(done),
    .packed_len(packed_len), .dst_vec(dst_vec)
  );

  task automatic check(input bit ok, input string req, input logic [N*W-1:0] act,
                       input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit m, input logic [N-1:0] mk, input int seed, input bit inject);
    logic [N*W-1:0] src, ini, exp;
    int cnt, n;
    string rq;
    for (int i = 0; i < N; i++) begin
      src[i*W +: W] = W'(16'h1000 * (seed % 15 + 1) + 16'h10 * i + mk);
      ini[i*W +: W] = W'(16'hE000 + 16'h100 * i + mk);
    end
    exp = ini;
    cnt = 0;
    for (int i = 0; i < N; i++) begin
      if (mk[i]) begin
        if (!m) exp[cnt*W +: W] = src[i*W +: W];
        else    exp[i*W +: W]   = src[cnt*W +: W];
        cnt++;
      end
    end
    @(negedge clk);
    mode = m; mask = mk; src_vec = src; dst_init = ini; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R6 busy after start", {{(N*W-1){1'b0}}, busy}, 1);
    n = 0;
    while (!done && n < 20) begin
      if (inject && n == 2) begin
        mode = ~m; mask = ~mk; src_vec = ~src; dst_init = ~ini; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    check(n == 8, "R6 done latency", (N*W)'(n), 8);
    if (inject) rq = "R7 start during busy";
    else if (mk == '0) rq = "R8 zero mask";
    else if (!m) rq = "R1/R2 compress";
    else rq = "R4/R5 expand";
    check(dst_vec === exp, rq, dst_vec, exp);
    check(packed_len === CW'(cnt), "R3 packed length", (N*W)'(packed_len), (N*W)'(cnt));
    @(negedge clk);
    check(done === 1'b0, "R6 done single pulse", {{(N*W-1){1'b0}}, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R9 reset flags", {busy, done}, 0);
    check(packed_len === '0, "R9 reset length", (N*W)'(packed_len), 0);
    check(dst_vec === '0, "R9 reset dest", dst_vec, 0);
    rst_n = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < (1 << N); k++)
        run_op(m[0], N'(k), k, 1'b0);
    run_op(1'b0, 8'b1010_0110, 3, 1'b1);
    run_op(1'b1, 8'b0111_0001, 5, 1'b1);
    run_op(1'b0, 8'h00, 7, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule